// File: doc/BRIEF.md
# Command-Response Buffer Control Registers

This block is the device-side register file of a command-response buffer interface. A host reaches it through a single-cycle 32-bit register port with byte addresses. Before the host owns the interface it must gain locality 0. The host moves the device between the idle and ready power states and places a command in a small shared data buffer. It then sets a start bit, and this launches a stub processing engine.

The start and cancel bits form a handshake that the device closes. A pulse on `eng_done` or `eng_abort` drops the start bit, and this frees the data buffer for host writes again. The command and response regions are the same buffer. Both therefore report the same offset and the same size.

Top module: `crb_regfile`

## Requirements
- R1: After reset the locality state reads 0x80, control status reads 0x2 (idle set), start reads 0, the request register reads 0 and interrupt enable reads 0.
- R2: In locality state, bit 7 always reads 1, bit 1 is "assigned" and bit 0 is "established". Bit 0 of the locality status register at 0x0C mirrors assigned. A write to locality control (0x08) with bit 0 set grants locality on the next cycle, and this also sets established, which stays set. A write with bit 1 set clears assigned on the next cycle. When both bits are set, bit 1 wins.
- R3: The interface ID register (0x30) reads 1 in bits [2:0] and 0 in all other bits.
- R4: A write to control request (0x40) latches bit 0 (go ready) and bit 1 (go idle). On the next cycle the idle flag (bit 1 of control status at 0x44) updates: go idle sets it and go ready clears it, and go idle wins when both are set. One cycle after that the request bits read 0 again.
- R5: Writing 1 to bit 0 of start (0x4C) sets start, and with it `eng_busy`, on the next cycle, but only while locality is assigned. Writing 0 to start has no effect.
- R6: While start is 1, a pulse on `eng_done` or `eng_abort` clears start on the next cycle. This takes priority over a host write of 1 to start in the same cycle.
- R7: Bit 0 of cancel (0x48) holds the written value and drives `eng_cancel`.
- R8: Only bit 31 of interrupt enable (0x50) can be written and read, and its other bits read 0. Interrupt status (0x54) reads 0.
- R9: The command size (0x58) and response size (0x64) both read BUF_WORDS*4. The low command and response address registers (0x5C, 0x68) both read 0x80. The high address registers (0x60, 0x6C) read 0.
- R10: The data buffer holds 32-bit word i at byte offset 0x80+4*i. It reads back what was written. A write while start is 1 is dropped.
- R11: Unmapped offsets, including those past the end of the buffer, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from state |
| eng_done | input | 1 | Engine finished the command |
| eng_abort | input | 1 | Engine carried out a cancel |
| eng_busy | output | 1 | Start bit, command in progress |
| eng_cancel | output | 1 | Cancel request to the engine |

## Verification
A host write and an engine event can land in the same cycle in two ways. The bench writes 1 to start in the cycle in which `eng_done` pulses, and it expects start to read 0 afterwards. It also writes the data buffer while a command runs, in the cycle before the engine completes, and it expects the old word to remain. A behavioural model updates on every clock and is compared against the read data for whatever address is on the port, so each collision is judged in the cycle it takes effect.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int OFF_LSTATE  = 'h00;
  localparam int OFF_LCTRL   = 'h08;
  localparam int OFF_LSTS    = 'h0C;
  localparam int OFF_IFID    = 'h30;
  localparam int OFF_CEXT    = 'h38;
  localparam int OFF_REQ     = 'h40;
  localparam int OFF_STS     = 'h44;
  localparam int OFF_CANCEL  = 'h48;
  localparam int OFF_START   = 'h4C;
  localparam int OFF_IEN     = 'h50;
  localparam int OFF_ISTS    = 'h54;
  localparam int OFF_CSIZE   = 'h58;
  localparam int OFF_CADDR_L = 'h5C;
  localparam int OFF_CADDR_H = 'h60;
  localparam int OFF_RSIZE   = 'h64;
  localparam int OFF_RADDR_L = 'h68;
  localparam int OFF_RADDR_H = 'h6C;
  localparam int OFF_BUF     = 'h80;

  localparam logic [2:0] IFTYPE_CRB = 3'd1;

  // Locality state word: valid in bit 7, assigned in bit 1, established in bit 0.
  function automatic logic [31:0] lstate_word(input logic assigned, input logic est);
    return {24'd0, 1'b1, 5'd0, assigned, est};
  endfunction

  // Go-idle wins over go-ready when both are requested.
  function automatic logic idle_after(input logic [1:0] req);
    return req[1];
  endfunction
endpackage

// File: rtl/crb_locality.sv
module crb_locality (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic want_bit,
  input  logic drop_bit,
  output logic assigned,
  output logic established
);
  logic grant_ev;
  logic drop_ev;

  assign drop_ev  = ctrl_wr && drop_bit;
  assign grant_ev = ctrl_wr && want_bit && !drop_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assigned    <= 1'b0;
      established <= 1'b0;
    end else begin
      if (drop_ev)       assigned <= 1'b0;
      else if (grant_ev) assigned <= 1'b1;
      if (grant_ev)      established <= 1'b1;
    end
  end
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [1:0] req_bits,
  input  logic       start_wr,
  input  logic       start_bit,
  input  logic       cancel_wr,
  input  logic       cancel_bit,
  input  logic       assigned,
  input  logic       eng_done,
  input  logic       eng_abort,
  output logic [1:0] req_q,
  output logic       idle,
  output logic       start,
  output logic       cancel,
  output logic       start_set_ev,
  output logic       start_clr_ev,
  output logic       req_apply_ev
);
  logic req_done;

  assign req_apply_ev = (req_q != 2'b00) && !req_done;
  assign start_clr_ev = start && (eng_done || eng_abort);
  assign start_set_ev = !start && start_wr && start_bit && assigned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 2'b00;
      req_done <= 1'b0;
      idle     <= 1'b1;
      start    <= 1'b0;
      cancel   <= 1'b0;
    end else begin
      req_done <= req_apply_ev;
      if (req_apply_ev) idle <= crb_pkg::idle_after(req_q);
      req_q <= (req_done ? 2'b00 : req_q) | (req_wr ? req_bits : 2'b00);
      if (cancel_wr) cancel <= cancel_bit;
      if (start_clr_ev)      start <= 1'b0;
      else if (start_set_ev) start <= 1'b1;
    end
  end
endmodule

// File: rtl/crb_databuf.sv
module crb_databuf #(
  parameter int WORDS = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 32'd0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile #(
  parameter int ADDR_W    = 12,
  parameter int BUF_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_done,
  input  logic              eng_abort,
  output logic              eng_busy,
  output logic              eng_cancel
);
  import crb_pkg::*;

  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam logic [ADDR_W-1:0] BUF_BASE = ADDR_W'(OFF_BUF);
  localparam logic [ADDR_W-1:0] BUF_END  = ADDR_W'(OFF_BUF + BUF_BYTES);

  logic              wr;
  logic              in_buf;
  logic [ADDR_W-1:0] buf_off;
  logic [IDX_W-1:0]  buf_idx;
  logic              loc_wr, req_wr, start_wr, cancel_wr, ien_wr, buf_we;
  logic              assigned, established, idle, start, cancel;
  logic [1:0]        req_q;
  logic              start_set_ev, start_clr_ev, req_apply_ev;
  logic              ien;
  logic [31:0]       buf_rdata;

  assign wr      = bus_sel && bus_we;
  assign in_buf  = (bus_addr >= BUF_BASE) && (bus_addr < BUF_END);
  assign buf_off = bus_addr - BUF_BASE;
  assign buf_idx = buf_off[IDX_W+1:2];

  assign loc_wr    = wr && (bus_addr == ADDR_W'(OFF_LCTRL));
  assign req_wr    = wr && (bus_addr == ADDR_W'(OFF_REQ));
  assign start_wr  = wr && (bus_addr == ADDR_W'(OFF_START));
  assign cancel_wr = wr && (bus_addr == ADDR_W'(OFF_CANCEL));
  assign ien_wr    = wr && (bus_addr == ADDR_W'(OFF_IEN));
  assign buf_we    = wr && in_buf && !start;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[30:2], bus_addr[1:0], buf_off};

  crb_locality u_loc (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(loc_wr),
    .want_bit(bus_wdata[0]), .drop_bit(bus_wdata[1]),
    .assigned(assigned), .established(established)
  );

  crb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_wr(req_wr), .req_bits(bus_wdata[1:0]),
    .start_wr(start_wr), .start_bit(bus_wdata[0]),
    .cancel_wr(cancel_wr), .cancel_bit(bus_wdata[0]),
    .assigned(assigned), .eng_done(eng_done), .eng_abort(eng_abort),
    .req_q(req_q), .idle(idle), .start(start), .cancel(cancel),
    .start_set_ev(start_set_ev), .start_clr_ev(start_clr_ev),
    .req_apply_ev(req_apply_ev)
  );

  crb_databuf #(.WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .idx(buf_idx),
    .wdata(bus_wdata), .rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      ien <= 1'b0;
    else if (ien_wr) ien <= bus_wdata[31];
  end

  assign eng_busy   = start;
  assign eng_cancel = cancel;

  always_comb begin
    bus_rdata = 32'd0;
    if (in_buf) begin
      bus_rdata = buf_rdata;
    end else begin
      case (bus_addr)
        ADDR_W'(OFF_LSTATE):  bus_rdata = lstate_word(assigned, established);
        ADDR_W'(OFF_LSTS):    bus_rdata = {31'd0, assigned};
        ADDR_W'(OFF_IFID):    bus_rdata = {29'd0, IFTYPE_CRB};
        ADDR_W'(OFF_REQ):     bus_rdata = {30'd0, req_q};
        ADDR_W'(OFF_STS):     bus_rdata = {30'd0, idle, 1'b0};
        ADDR_W'(OFF_CANCEL):  bus_rdata = {31'd0, cancel};
        ADDR_W'(OFF_START):   bus_rdata = {31'd0, start};
        ADDR_W'(OFF_IEN):     bus_rdata = {ien, 31'd0};
        ADDR_W'(OFF_CSIZE),
        ADDR_W'(OFF_RSIZE):   bus_rdata = 32'(BUF_BYTES);
        ADDR_W'(OFF_CADDR_L),
        ADDR_W'(OFF_RADDR_L): bus_rdata = 32'(OFF_BUF);
        default:              bus_rdata = 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/crb_regfile_chk.sv
module crb_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        loc_wr,
  input logic        cancel_wr,
  input logic [31:0] bus_wdata,
  input logic        assigned,
  input logic        idle,
  input logic [1:0]  req_q,
  input logic        buf_we,
  input logic        eng_done,
  input logic        eng_abort,
  input logic        eng_busy,
  input logic        eng_cancel
);
  AST_LOC_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && bus_wdata[0] && !bus_wdata[1]) |=> assigned); // R2
  AST_LOC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && bus_wdata[1]) |=> !assigned); // R2
  AST_IDLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(req_q[1])); // R4
  AST_START_NEEDS_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(assigned)); // R5
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && (eng_done || eng_abort)) |=> !eng_busy); // R6
  AST_CANCEL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_wr |=> (eng_cancel == $past(bus_wdata[0]))); // R7
  AST_BUF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !eng_busy); // R10
endmodule

bind crb_regfile crb_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loc_wr(loc_wr), .cancel_wr(cancel_wr),
  .bus_wdata(bus_wdata), .assigned(assigned), .idle(idle), .req_q(req_q),
  .buf_we(buf_we), .eng_done(eng_done), .eng_abort(eng_abort),
  .eng_busy(eng_busy), .eng_cancel(eng_cancel)
);

// File: tb/crb_regfile_test.sv
module crb_regfile_test;
  localparam int CLK_P  = 10;
  localparam int AW     = 12;
  localparam int WORDS  = 32;
  localparam int NBYTES = WORDS * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          eng_done = 1'b0, eng_abort = 1'b0;
  logic          eng_busy, eng_cancel;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  crb_regfile #(.ADDR_W(AW), .BUF_WORDS(WORDS)) uut (.*);

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference model
  int m_as, m_est, m_idle, m_req, m_rdone, m_start, m_cancel, m_ien;
  int m_buf [WORDS];

  task automatic model_reset();
    m_as = 0; m_est = 0; m_idle = 1; m_req = 0; m_rdone = 0;
    m_start = 0; m_cancel = 0; m_ien = 0;
    foreach (m_buf[i]) m_buf[i] = 0;
  endtask

  always @(posedge clk) begin
    int a, d, wr;
    if (!rst_n) model_reset();
    else begin
      a  = int'(bus_addr);
      d  = int'(bus_wdata);
      wr = int'(bus_sel && bus_we);
      if (wr != 0 && a >= 'h80 && a < 'h80 + NBYTES && m_start == 0)
        m_buf[(a - 'h80) / 4] = d;
      if (m_start != 0 && (eng_done || eng_abort)) m_start = 0;
      else if (wr != 0 && a == 'h4C && d[0] && m_as != 0) m_start = 1;
      if (wr != 0 && a == 'h48) m_cancel = d & 1;
      if (wr != 0 && a == 'h50) m_ien = (d >> 31) & 1;
      if (wr != 0 && a == 'h08) begin
        if (d[1]) m_as = 0;
        else if (d[0]) begin m_as = 1; m_est = 1; end
      end
      if (m_rdone != 0) begin
        m_req = 0; m_rdone = 0;
      end else if (m_req != 0) begin
        m_idle = (m_req & 2) != 0 ? 1 : 0;
        m_rdone = 1;
      end
      if (wr != 0 && a == 'h40) m_req = m_req | (d & 3);
    end
  end

  function automatic int exp_rd(int a);
    if (a >= 'h80 && a < 'h80 + NBYTES) return m_buf[(a - 'h80) / 4];
    case (a)
      'h00: return 'h80 | (m_as << 1) | m_est;
      'h0C: return m_as;
      'h30: return 1;
      'h40: return m_req;
      'h44: return m_idle << 1;
      'h48: return m_cancel;
      'h4C: return m_start;
      'h50: return m_ien << 31;
      'h58, 'h64: return NBYTES;
      'h5C, 'h68: return 'h80;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a >= 'h80 && a < 'h80 + NBYTES) return "R10";
    case (a)
      'h00, 'h0C: return "R2";
      'h30: return "R3";
      'h40, 'h44: return "R4";
      'h48: return "R7";
      'h4C: return "R5";
      'h50, 'h54: return "R8";
      'h58, 'h5C, 'h60, 'h64, 'h68, 'h6C: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Every-clock comparison against the model
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      vectors++;
      if (bus_rdata !== 32'(exp_rd(int'(bus_addr)))) begin
        misses++;
        $display("FAIL %s clock compare addr=%h got=%h exp=%h",
                 tag_of(int'(bus_addr)), bus_addr, bus_rdata, exp_rd(int'(bus_addr)));
      end
      vectors++;
      if (eng_busy !== (m_start != 0) || eng_cancel !== (m_cancel != 0)) begin
        misses++;
        $display("FAIL R5 busy/cancel pins got=%b%b exp=%0d%0d",
                 eng_busy, eng_cancel, m_start, m_cancel);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int a, string tag, logic [31:0] exp);
    bus_addr = AW'(a);
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic pulse(input bit done, input bit abort);
    eng_done = done; eng_abort = abort;
    @(negedge clk);
    eng_done = 1'b0; eng_abort = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      misses++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd('h00, "R1", 32'h80);
    rd('h44, "R1", 32'h2);
    rd('h4C, "R1", 32'h0);
    rd('h40, "R1", 32'h0);
    rd('h50, "R1", 32'h0);
    // R3 and R9 constants, R8 status
    rd('h30, "R3", 32'h1);
    rd('h54, "R8", 32'h0);
    rd('h58, "R9", NBYTES);
    rd('h64, "R9", NBYTES);
    rd('h5C, "R9", 32'h80);
    rd('h68, "R9", 32'h80);
    rd('h60, "R9", 32'h0);
    rd('h6C, "R9", 32'h0);
    // R5 start ignored without locality
    wr('h4C, 32'h1);
    rd('h4C, "R5", 32'h0);
    // R2 grant
    wr('h08, 32'h1);
    rd('h00, "R2", 32'h83);
    rd('h0C, "R2", 32'h1);
    // R10 buffer
    for (int i = 0; i < 4; i++) wr('h80 + 4*i, 32'hA5A5_0000 + i);
    for (int i = 0; i < 4; i++) rd('h80 + 4*i, "R10", 32'hA5A5_0000 + i);
    wr('h80 + 4*(WORDS-1), 32'hCAFE_F00D);
    rd('h80 + 4*(WORDS-1), "R10", 32'hCAFE_F00D);
    // R4 go ready then timing
    wr('h40, 32'h1);
    rd('h40, "R4", 32'h1);
    rd('h44, "R4", 32'h0);
    rd('h40, "R4", 32'h0);
    // R4 both requested: idle wins
    wr('h40, 32'h3);
    rd('h44, "R4", 32'h0);
    rd('h44, "R4", 32'h2);
    rd('h40, "R4", 32'h0);
    // R7 cancel
    wr('h48, 32'h1);
    chk("R7", eng_cancel, 1);
    rd('h48, "R7", 32'h1);
    wr('h48, 32'h0);
    chk("R7", eng_cancel, 0);
    // R8 interrupt enable
    wr('h50, 32'hFFFF_FFFF);
    rd('h50, "R8", 32'h8000_0000);
    // R5 start, write 0 ignored
    wr('h4C, 32'h1);
    chk("R5", eng_busy, 1);
    wr('h4C, 32'h0);
    rd('h4C, "R5", 32'h1);
    // R10 buffer locked while busy, in the cycle before completion
    wr('h80, 32'h1111_2222);
    pulse(1'b1, 1'b0);
    rd('h80, "R10", 32'hA5A5_0000);
    chk("R6", eng_busy, 0);
    // R6 done collides with host start write
    wr('h4C, 32'h1);
    eng_done = 1'b1;
    wr('h4C, 32'h1);
    eng_done = 1'b0;
    rd('h4C, "R6", 32'h0);
    // R6 abort
    wr('h4C, 32'h1);
    pulse(1'b0, 1'b1);
    rd('h4C, "R6", 32'h0);
    // R10 accepted again after completion
    wr('h80, 32'h3333_4444);
    rd('h80, "R10", 32'h3333_4444);
    // R2 relinquish, established stays; both bits -> relinquish wins
    wr('h08, 32'h2);
    rd('h00, "R2", 32'h81);
    wr('h08, 32'h1);
    wr('h08, 32'h3);
    rd('h00, "R2", 32'h81);
    wr('h4C, 32'h1);
    rd('h4C, "R5", 32'h0);
    // R11 unmapped
    wr('h20, 32'hFFFF_FFFF);
    rd('h20, "R11", 32'h0);
    rd('h38, "R11", 32'h0);
    wr('h80 + NBYTES, 32'h1234_5678);
    rd('h80 + NBYTES, "R11", 32'h0);
    rd('h00, "R11", 32'h81);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule